// File: doc/BRIEF.md
# Function Code Context Router

This block sits between a processor bus, the I/O masters that do DMA, and a page-map translator. Every processor cycle carries a 3-bit function code. The router sorts each cycle into one of four routes:

- translation through the page map, with a chosen context;
- the control address space;
- a direct read of the boot PROM;
- an error response.

DMA requests always use the system context. They take a fixed base address unless the master sits on the on-board I/O bus. The router also holds the user context register, the system context register and the boot/run mode. It exports a combined 4-bit context number. It raises a one-cycle flush pulse that tells translation caches to drop every entry.

The mode is a two-state machine:

- `MODE_BOOT` is entered at reset and by the transition `RETURN_BOOT`. That transition is a write to the enable register with the run bit clear.
- `MODE_RUN` is entered by the transition `ENTER_RUN`. That transition is a write to the enable register with the run bit set.
- Any other cycle holds the state.

In `MODE_BOOT`, only supervisor program fetches are redirected to the PROM. Supervisor data cycles are still translated.

Configuration writes use `cfg_sel`:

| `cfg_sel` | Target |
|---|---|
| 0 | user context |
| 1 | system context |
| 2 | enable register |
| 3 | none |

A context write takes `cfg_wdata[2:0]`. The run bit is `cfg_wdata[0]`.

Top module: `fcr_router`

## Requirements
- R1: Reset state:
  - mode is `MODE_BOOT` and both context registers are 0;
  - `ctx_export` is 8 and `xlate_flush` is low;
  - neither response port is valid.
- R2: Mode and exported context:
  - an enable write with `cfg_wdata[0]`=1 moves to `MODE_RUN`; with `cfg_wdata[0]`=0 it moves to `MODE_BOOT`;
  - `boot_mode` is 1 in `MODE_BOOT`;
  - `ctx_export` equals the user context plus 8 in boot mode, and the user context alone in run mode;
  - a write with `cfg_sel`=3 changes neither the mode, the contexts nor the flush.
- R3: Function codes 1 (user data) and 2 (user program) give route kind 0 (translate). They carry the user context, the unchanged address, and rights bit1=1 (user) with bit0 equal to the write flag.
- R4: In run mode, function codes 5 (supervisor data) and 6 (supervisor program) give kind 0. They carry the system context, the unchanged address, and rights bit1=0 (supervisor) with bit0 equal to the write flag.
- R5: Function code 3 gives kind 1 (control) in either mode. It carries the unchanged address, context 0, and supervisor rights with bit0 equal to the write flag, so both reads and writes are allowed.
- R6: In boot mode, a function code 6 read gives kind 2 (PROM) with `cpu_rsp_prom`=1. Its address is `PROM_BASE` OR the address modulo 2^`PROM_AW`, with context 0 and rights 00 (supervisor read-only). A function code 6 write in boot mode gives kind 3 (fault).
- R7: In boot mode, function code 5 is translated exactly as in R4.
- R8: Function codes 0, 4 and 7 give kind 3 (fault) with context, address and rights all 0.
- R9: `xlate_flush` is high for exactly the cycle after each system-context write. It is never raised by user-context, enable or unused writes.
- R10: A DMA request responds with the system context and rights bit1=0 with bit0 equal to its write flag. Its address is the request address OR `DMA_BASE` (0xF00000) when `dma_onboard`=0, and the request address unchanged when `dma_onboard`=1.
- R11: Each response appears exactly one cycle after its request. A request uses the register values held before a configuration write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 user ctx, 1 system ctx, 2 enable, 3 none |
| cfg_wdata | input | 3 | Write data (context value, or run bit in bit 0) |
| cpu_valid | input | 1 | Processor cycle present |
| cpu_fc | input | 3 | Processor function code |
| cpu_addr | input | 24 | Processor address |
| cpu_write | input | 1 | Processor cycle is a write |
| dma_valid | input | 1 | DMA request present |
| dma_onboard | input | 1 | DMA master is on the on-board I/O bus |
| dma_addr | input | 24 | DMA address |
| dma_write | input | 1 | DMA request is a write |
| cpu_rsp_valid | output | 1 | Processor route result valid |
| cpu_rsp_kind | output | 2 | 0 translate, 1 control, 2 PROM, 3 fault |
| cpu_rsp_ctx | output | 3 | Context for translation |
| cpu_rsp_addr | output | 24 | Routed address |
| cpu_rsp_rights | output | 2 | Required rights: bit1 user, bit0 write |
| cpu_rsp_prom | output | 1 | PROM bypass taken |
| dma_rsp_valid | output | 1 | DMA route result valid |
| dma_rsp_ctx | output | 3 | Context for DMA translation |
| dma_rsp_addr | output | 24 | DMA address after base insertion |
| dma_rsp_rights | output | 2 | Required rights for DMA |
| boot_mode | output | 1 | Mode machine is in `MODE_BOOT` |
| ctx_export | output | 4 | Combined context number 0..15 |
| xlate_flush | output | 1 | Drop all cached translations |

## Verification
The assertions check these properties on every cycle:

- the flush has a system-context write as its cause;
- the mode follows each enable write and holds otherwise;
- every control cycle leaves as a control route with its address intact;
- reserved codes always fault;
- a PROM route never grants write rights;
- DMA results carry supervisor rights and the base bits.

The exact PROM address arithmetic, the difference between user and system contexts, and the same-cycle ordering between a configuration write and a request depend on particular sequences of writes and cycles. Only the bench's scenarios, compared against its behavioural model, can show those.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    typedef enum logic [1:0] {
        RK_XLATE = 2'd0,
        RK_CTRL  = 2'd1,
        RK_PROM  = 2'd2,
        RK_FAULT = 2'd3
    } route_kind_t;

    typedef enum logic [1:0] {
        SEL_UCTX = 2'd0,
        SEL_SCTX = 2'd1,
        SEL_ENA  = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_t;

    typedef enum logic {
        MODE_BOOT = 1'b0,
        MODE_RUN  = 1'b1
    } mode_t;

    localparam logic [2:0] FC_UDATA = 3'd1;
    localparam logic [2:0] FC_UPROG = 3'd2;
    localparam logic [2:0] FC_CTRL  = 3'd3;
    localparam logic [2:0] FC_SDATA = 3'd5;
    localparam logic [2:0] FC_SPROG = 3'd6;

endpackage

// File: rtl/fcr_mode_fsm.sv
module fcr_mode_fsm
    import fcr_pkg::*;
#(
    parameter int CTX_W       = 3,
    parameter int NOTBOOT_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CTX_W-1:0] cfg_wdata,
    output logic             boot,
    output logic [CTX_W-1:0] user_ctx,
    output logic [CTX_W-1:0] sys_ctx,
    output logic [CTX_W:0]   ctx_export,
    output logic             flush
);

    mode_t state_q, state_d;
    logic  wr_user, wr_sys, wr_ena;

    always_comb begin
        wr_user = cfg_we && (cfg_sel == SEL_UCTX);
        wr_sys  = cfg_we && (cfg_sel == SEL_SCTX);
        wr_ena  = cfg_we && (cfg_sel == SEL_ENA);
    end

    // next-state: ENTER_RUN and RETURN_BOOT transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_BOOT: if (wr_ena && cfg_wdata[NOTBOOT_BIT])  state_d = MODE_RUN;
            MODE_RUN:  if (wr_ena && !cfg_wdata[NOTBOOT_BIT]) state_d = MODE_BOOT;
            default:   state_d = MODE_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_BOOT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            user_ctx <= '0;
            sys_ctx  <= '0;
            flush    <= 1'b0;
        end else begin
            if (wr_user) user_ctx <= cfg_wdata;
            if (wr_sys)  sys_ctx  <= cfg_wdata;
            flush <= wr_sys;
        end
    end

    // outputs: boot contexts sit above the run contexts
    always_comb begin
        boot       = (state_q == MODE_BOOT);
        ctx_export = {boot, user_ctx};
    end

    // R9
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> $past(cfg_we && (cfg_sel == SEL_SCTX)));

    // R2
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cfg_we && (cfg_sel == SEL_ENA))
        |-> boot == !$past(cfg_wdata[NOTBOOT_BIT]));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(cfg_we && (cfg_sel == SEL_ENA)) |-> $stable(boot));

endmodule

// File: rtl/fcr_cpu_route.sv
module fcr_cpu_route
    import fcr_pkg::*;
#(
    parameter int                ADDR_W    = 24,
    parameter int                CTX_W     = 3,
    parameter int                PROM_AW   = 15,
    parameter logic [ADDR_W-1:0] PROM_BASE = 24'hEF8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_fc,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              boot,
    input  logic [CTX_W-1:0]  user_ctx,
    input  logic [CTX_W-1:0]  sys_ctx,
    output logic              rsp_valid,
    output route_kind_t       rsp_kind,
    output logic [CTX_W-1:0]  rsp_ctx,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [1:0]        rsp_rights
);

    localparam int HI_W = ADDR_W - PROM_AW;

    route_kind_t       kind_d;
    logic [CTX_W-1:0]  ctx_d;
    logic [ADDR_W-1:0] addr_d;
    logic [1:0]        rights_d;
    logic [ADDR_W-1:0] prom_addr;

    assign prom_addr = PROM_BASE | {{HI_W{1'b0}}, req_addr[PROM_AW-1:0]};

    always_comb begin
        kind_d   = RK_FAULT;
        ctx_d    = '0;
        addr_d   = '0;
        rights_d = 2'b00;
        unique case (req_fc)
            FC_UDATA, FC_UPROG: begin
                kind_d   = RK_XLATE;
                ctx_d    = user_ctx;
                addr_d   = req_addr;
                rights_d = {1'b1, req_write};
            end
            FC_CTRL: begin
                kind_d   = RK_CTRL;
                addr_d   = req_addr;
                rights_d = {1'b0, req_write};
            end
            FC_SDATA: begin
                kind_d   = RK_XLATE;
                ctx_d    = sys_ctx;
                addr_d   = req_addr;
                rights_d = {1'b0, req_write};
            end
            FC_SPROG: begin
                if (!boot) begin
                    kind_d   = RK_XLATE;
                    ctx_d    = sys_ctx;
                    addr_d   = req_addr;
                    rights_d = {1'b0, req_write};
                end else if (!req_write) begin
                    kind_d   = RK_PROM;
                    addr_d   = prom_addr;
                end
            end
            default: kind_d = RK_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid  <= 1'b0;
            rsp_kind   <= RK_XLATE;
            rsp_ctx    <= '0;
            rsp_addr   <= '0;
            rsp_rights <= 2'b00;
        end else begin
            rsp_valid  <= 1'b1;
            rsp_kind   <= kind_d;
            rsp_ctx    <= ctx_d;
            rsp_addr   <= addr_d;
            rsp_rights <= rights_d;
        end
    end

    // R11
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rsp_valid == $past(req_valid));

    // R5
    ctrl_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid && (req_fc == FC_CTRL))
        |-> rsp_kind == RK_CTRL && rsp_addr == $past(req_addr));

    // R8
    rsvd_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid && (req_fc == 3'd0 || req_fc == 3'd4 || req_fc == 3'd7))
        |-> rsp_kind == RK_FAULT);

    // R6
    prom_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_kind == RK_PROM) |-> rsp_rights == 2'b00);

    // R3
    user_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid && (req_fc == FC_UDATA || req_fc == FC_UPROG))
        |-> rsp_ctx == $past(user_ctx) && rsp_rights[1]);

endmodule

// File: rtl/fcr_dma_map.sv
module fcr_dma_map #(
    parameter int                ADDR_W   = 24,
    parameter int                CTX_W    = 3,
    parameter logic [ADDR_W-1:0] DMA_BASE = 24'hF00000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_onboard,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [CTX_W-1:0]  sys_ctx,
    output logic              rsp_valid,
    output logic [CTX_W-1:0]  rsp_ctx,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [1:0]        rsp_rights
);

    logic [ADDR_W-1:0] base_sel;

    assign base_sel = req_onboard ? '0 : DMA_BASE;

    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid  <= 1'b0;
            rsp_ctx    <= '0;
            rsp_addr   <= '0;
            rsp_rights <= 2'b00;
        end else begin
            rsp_valid  <= 1'b1;
            rsp_ctx    <= sys_ctx;
            rsp_addr   <= req_addr | base_sel;
            rsp_rights <= {1'b0, req_write};
        end
    end

    // R10
    dma_super_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !rsp_rights[1] && rsp_ctx == $past(sys_ctx));

    // R10
    dma_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid && !req_onboard)
        |-> (rsp_addr & DMA_BASE) == DMA_BASE);

endmodule

// File: rtl/fcr_router.sv
module fcr_router
    import fcr_pkg::*;
#(
    parameter int                ADDR_W      = 24,
    parameter int                CTX_W       = 3,
    parameter int                NOTBOOT_BIT = 0,
    parameter int                PROM_AW     = 15,
    parameter logic [ADDR_W-1:0] PROM_BASE   = 24'hEF8000,
    parameter logic [ADDR_W-1:0] DMA_BASE    = 24'hF00000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CTX_W-1:0]  cfg_wdata,
    input  logic              cpu_valid,
    input  logic [2:0]        cpu_fc,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_write,
    input  logic              dma_valid,
    input  logic              dma_onboard,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic              dma_write,
    output logic              cpu_rsp_valid,
    output logic [1:0]        cpu_rsp_kind,
    output logic [CTX_W-1:0]  cpu_rsp_ctx,
    output logic [ADDR_W-1:0] cpu_rsp_addr,
    output logic [1:0]        cpu_rsp_rights,
    output logic              cpu_rsp_prom,
    output logic              dma_rsp_valid,
    output logic [CTX_W-1:0]  dma_rsp_ctx,
    output logic [ADDR_W-1:0] dma_rsp_addr,
    output logic [1:0]        dma_rsp_rights,
    output logic              boot_mode,
    output logic [CTX_W:0]    ctx_export,
    output logic              xlate_flush
);

    logic             boot;
    logic [CTX_W-1:0] user_ctx, sys_ctx;
    route_kind_t      kind;

    fcr_mode_fsm #(
        .CTX_W       (CTX_W),
        .NOTBOOT_BIT (NOTBOOT_BIT)
    ) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .boot       (boot),
        .user_ctx   (user_ctx),
        .sys_ctx    (sys_ctx),
        .ctx_export (ctx_export),
        .flush      (xlate_flush)
    );

    fcr_cpu_route #(
        .ADDR_W    (ADDR_W),
        .CTX_W     (CTX_W),
        .PROM_AW   (PROM_AW),
        .PROM_BASE (PROM_BASE)
    ) u_cpu (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (cpu_valid),
        .req_fc     (cpu_fc),
        .req_addr   (cpu_addr),
        .req_write  (cpu_write),
        .boot       (boot),
        .user_ctx   (user_ctx),
        .sys_ctx    (sys_ctx),
        .rsp_valid  (cpu_rsp_valid),
        .rsp_kind   (kind),
        .rsp_ctx    (cpu_rsp_ctx),
        .rsp_addr   (cpu_rsp_addr),
        .rsp_rights (cpu_rsp_rights)
    );

    fcr_dma_map #(
        .ADDR_W   (ADDR_W),
        .CTX_W    (CTX_W),
        .DMA_BASE (DMA_BASE)
    ) u_dma (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (dma_valid),
        .req_onboard (dma_onboard),
        .req_addr    (dma_addr),
        .req_write   (dma_write),
        .sys_ctx     (sys_ctx),
        .rsp_valid   (dma_rsp_valid),
        .rsp_ctx     (dma_rsp_ctx),
        .rsp_addr    (dma_rsp_addr),
        .rsp_rights  (dma_rsp_rights)
    );

    always_comb begin
        cpu_rsp_kind = kind;
        cpu_rsp_prom = cpu_rsp_valid && (kind == RK_PROM);
        boot_mode    = boot;
    end

endmodule

// File: tb/fcr_router_tb.sv
module fcr_router_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [2:0]  cfg_wdata = 3'd0;
    logic        cpu_valid = 1'b0;
    logic [2:0]  cpu_fc = 3'd0;
    logic [23:0] cpu_addr = 24'd0;
    logic        cpu_write = 1'b0;
    logic        dma_valid = 1'b0;
    logic        dma_onboard = 1'b0;
    logic [23:0] dma_addr = 24'd0;
    logic        dma_write = 1'b0;
    logic        cpu_rsp_valid, cpu_rsp_prom, dma_rsp_valid, boot_mode, xlate_flush;
    logic [1:0]  cpu_rsp_kind, cpu_rsp_rights, dma_rsp_rights;
    logic [2:0]  cpu_rsp_ctx, dma_rsp_ctx;
    logic [23:0] cpu_rsp_addr, dma_rsp_addr;
    logic [3:0]  ctx_export;

    integer n_run = 0;
    integer n_fail = 0;

    // behavioural model state
    bit       m_boot = 1'b1;
    bit [2:0] m_uctx = 3'd0;
    bit [2:0] m_sctx = 3'd0;

    always #4 clk = ~clk;

    fcr_router u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cpu_valid(cpu_valid), .cpu_fc(cpu_fc), .cpu_addr(cpu_addr), .cpu_write(cpu_write),
        .dma_valid(dma_valid), .dma_onboard(dma_onboard), .dma_addr(dma_addr), .dma_write(dma_write),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_kind(cpu_rsp_kind), .cpu_rsp_ctx(cpu_rsp_ctx),
        .cpu_rsp_addr(cpu_rsp_addr), .cpu_rsp_rights(cpu_rsp_rights), .cpu_rsp_prom(cpu_rsp_prom),
        .dma_rsp_valid(dma_rsp_valid), .dma_rsp_ctx(dma_rsp_ctx), .dma_rsp_addr(dma_rsp_addr),
        .dma_rsp_rights(dma_rsp_rights), .boot_mode(boot_mode), .ctx_export(ctx_export),
        .xlate_flush(xlate_flush)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one clock: model predicts, DUT clocks, compare away from the edge
    task automatic tick(input string tag);
        logic [33:0] e_cpu;
        logic [30:0] e_dma;
        logic        e_flush;
        logic [1:0]  k;
        logic [2:0]  c;
        logic [23:0] a;
        logic [1:0]  r;
        k = 2'd3; c = 3'd0; a = 24'd0; r = 2'b00;
        case (cpu_fc)
            3'd1, 3'd2: begin k = 2'd0; c = m_uctx; a = cpu_addr; r = {1'b1, cpu_write}; end
            3'd3:       begin k = 2'd1; a = cpu_addr; r = {1'b0, cpu_write}; end
            3'd5:       begin k = 2'd0; c = m_sctx; a = cpu_addr; r = {1'b0, cpu_write}; end
            3'd6: begin
                if (!m_boot) begin k = 2'd0; c = m_sctx; a = cpu_addr; r = {1'b0, cpu_write}; end
                else if (!cpu_write) begin k = 2'd2; a = 24'hEF8000 | (cpu_addr & 24'h007FFF); end
            end
            default: ;
        endcase
        if (cpu_valid) e_cpu = {1'b1, k, c, a, r, (k == 2'd2)};
        else           e_cpu = '0;
        if (dma_valid) e_dma = {1'b1, m_sctx, dma_addr | (dma_onboard ? 24'h0 : 24'hF00000), 1'b0, dma_write};
        else           e_dma = '0;
        e_flush = cfg_we && (cfg_sel == 2'd1);
        if (cfg_we) begin
            case (cfg_sel)
                2'd0: m_uctx = cfg_wdata;
                2'd1: m_sctx = cfg_wdata;
                2'd2: m_boot = !cfg_wdata[0];
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, "cpu rsp", {30'd0, cpu_rsp_valid, cpu_rsp_kind, cpu_rsp_ctx, cpu_rsp_addr, cpu_rsp_rights, cpu_rsp_prom},
            {30'd0, e_cpu});
        chk(tag, "dma rsp", {33'd0, dma_rsp_valid, dma_rsp_ctx, dma_rsp_addr, dma_rsp_rights}, {33'd0, e_dma});
        chk(tag, "mode/ctx", {59'd0, boot_mode, ctx_export}, {59'd0, m_boot, m_boot, m_uctx});
        chk(tag, "flush", {63'd0, xlate_flush}, {63'd0, e_flush});
    endtask

    task automatic idle();
        cfg_we = 0; cpu_valid = 0; dma_valid = 0; cpu_write = 0; dma_write = 0;
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [2:0] d);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    endtask

    task automatic cpu(input logic [2:0] fc, input logic [23:0] ad, input logic wr);
        cpu_valid = 1; cpu_fc = fc; cpu_addr = ad; cpu_write = wr;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "reset", {cpu_rsp_valid, dma_rsp_valid, boot_mode, ctx_export, xlate_flush},
            {1'b0, 1'b0, 1'b1, 4'd8, 1'b0});

        idle(); cfg(2'd0, 3'd5); tick("R9");            // user ctx write, no flush
        idle(); cfg(2'd1, 3'd3); tick("R9");            // system ctx write, flush
        idle(); tick("R9");                              // flush drops
        idle(); cpu(3'd6, 24'h123456, 0); tick("R6");    // PROM bypass
        idle(); cpu(3'd6, 24'hFFFFFF, 0); tick("R6");
        idle(); cpu(3'd6, 24'h000100, 1); tick("R6");    // PROM write faults
        idle(); cpu(3'd5, 24'h0ABCDE, 1); tick("R7");
        idle(); cpu(3'd1, 24'h111111, 0); tick("R3");
        idle(); cpu(3'd2, 24'h222222, 1); tick("R3");
        idle(); cpu(3'd3, 24'h333333, 0); tick("R5");
        idle(); cpu(3'd3, 24'h444444, 1); tick("R5");
        idle(); cpu(3'd0, 24'h555555, 0); tick("R8");
        idle(); cpu(3'd4, 24'h666666, 1); tick("R8");
        idle(); cpu(3'd7, 24'h777777, 0); tick("R8");
        idle(); dma_valid = 1; dma_onboard = 0; dma_addr = 24'h001234; dma_write = 1; tick("R10");
        idle(); dma_valid = 1; dma_onboard = 1; dma_addr = 24'h801234; dma_write = 0; tick("R10");
        // same-cycle write and request: old context used
        idle(); cfg(2'd1, 3'd6); cpu(3'd5, 24'h010101, 0);
        dma_valid = 1; dma_onboard = 0; dma_addr = 24'h00ABCD; tick("R11");
        idle(); cpu(3'd5, 24'h020202, 0); dma_valid = 1; dma_addr = 24'h000010; tick("R11");
        idle(); cfg(2'd0, 3'd2); cpu(3'd1, 24'h030303, 0); tick("R11");
        idle(); cpu(3'd2, 24'h040404, 0); tick("R11");
        // enter run mode
        idle(); cfg(2'd2, 3'd1); tick("R2");
        idle(); cpu(3'd6, 24'h123456, 0); tick("R4");
        idle(); cpu(3'd6, 24'h123456, 1); tick("R4");
        idle(); cpu(3'd5, 24'h654321, 1); tick("R4");
        idle(); cfg(2'd3, 3'd0); tick("R2");             // unused target has no effect
        idle(); cpu(3'd6, 24'h0000AA, 0); tick("R2");
        idle(); cfg(2'd2, 3'd0); tick("R2");             // back to boot
        idle(); cpu(3'd6, 24'h00ABCD, 0); tick("R6");
        // sweep all codes, both modes, both directions, with config churn
        for (int m = 0; m < 2; m++) begin
            idle(); cfg(2'd2, 3'(m)); tick("R2");
            for (int f = 0; f < 8; f++) begin
                for (int w = 0; w < 2; w++) begin
                    idle();
                    cpu(3'(f), 24'(32'h00F00F * (f + 1) + w * 32'h8000 + m * 32'h50000), 1'(w));
                    dma_valid = 1; dma_onboard = 1'(f & 1); dma_addr = 24'(f * 32'h1111); dma_write = 1'(w);
                    if (w == 1) cfg(2'(f % 2), 3'(f + m));
                    tick("R3");
                end
            end
        end
        idle(); tick("R9");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule